// File: doc/BRIEF.md
# Multi-Operand Read Scheduler

This block sits in the decode stage of a pipeline whose register file has only two read ports. It serves custom instructions that need three or four source operands. Each cycle it looks at the decoded instruction class and at the source index fields of the instruction word now in decode and of the word after it. From these it drives the two read address ports. It then steers the returned data into four operand latches that feed the custom functional unit.

Instructions with at most two sources finish their reads in one decode slot. Instructions with three or four sources take a second decode slot. During that slot the read ports fetch the remaining operands into latches three and four. For a one-word three-source class, the third index comes from the middle field of the same word, which is read again. For two-word classes, the indices come from the following word, which this second slot consumes. While the second slot runs, `busy` is high and the decode inputs are ignored. One cycle after the last read, `op_valid` pulses with all four latches filled, and any latch the class does not use holds zero.

Top module: `opread_sched`

## Requirements
- R1: After reset, all four operand outputs are zero, and `op_valid`, `busy`, `rd_en0` and `rd_en1` are low.
- R2: Class codes on `in_cls` are: 0 plain, 1 custom 2-in/1-out, 2 custom 2-in/2-out, 3 custom 3-in/1-out (one word), 4 custom 3-in/2-out, 5 custom 4-in/1-out, 6 custom 4-in/2-out (two words each), 7 reserved and handled like 0. In a first decode slot with `in_valid` high, port 0 reads `cur_a`. Port 1 reads `cur_b` for codes 0, 1 and 7, and `cur_c` for all other codes.
- R3: For codes 0, 1, 2 and 7, `op_valid` rises on the clock after the first slot. At that point `opnd1` and `opnd2` hold the port 0 and port 1 data read in that slot, and `opnd3` and `opnd4` are zero.
- R4: For code 3, the cycle after the first slot is a second slot with `busy` high. In it, port 0 reads the index `cur_b` captured in the first slot and port 1 is disabled. On the clock after that, `op_valid` rises with `opnd3` holding that data and `opnd4` zero.
- R5: For codes 4, 5 and 6, the second slot reads the captured `nxt_a` on port 0. For codes 5 and 6 it also reads `nxt_b` on port 1; for code 4 port 1 is disabled. When `op_valid` rises, `opnd3` holds the port 0 data and `opnd4` holds the port 1 data, or zero for code 4.
- R6: During a second slot, `in_valid`, `in_cls` and all index fields have no effect on the read addresses or on the resulting operands. A new instruction is accepted in the cycle right after the second slot.
- R7: `opnd1` and `opnd2` keep their first-slot values through the second slot and the result cycle. All four operands hold their values in cycles where no instruction is accepted.
- R8: A disabled read port drives address zero. With no valid instruction and no second slot, both ports are disabled.
- R9: `op_valid` is a one-cycle pulse, given exactly once per accepted instruction, and `op_cls` then reports that instruction's class code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present in decode |
| in_cls | input | 3 | Decoded instruction class code |
| cur_a | input | IDX_W | First source field of the current word |
| cur_b | input | IDX_W | Middle field of the current word (source or destination by class) |
| cur_c | input | IDX_W | Third field of the current word |
| nxt_a | input | IDX_W | First source field of the following word |
| nxt_b | input | IDX_W | Second source field of the following word |
| rd_en0 | output | 1 | Read port 0 enable |
| rd_addr0 | output | IDX_W | Read port 0 address |
| rd_en1 | output | 1 | Read port 1 enable |
| rd_addr1 | output | IDX_W | Read port 1 address |
| rd_data0 | input | DATA_W | Read port 0 data, same cycle |
| rd_data1 | input | DATA_W | Read port 1 data, same cycle |
| busy | output | 1 | Second decode slot in progress |
| op_valid | output | 1 | Operand set complete |
| op_cls | output | 3 | Class of the completed operand set |
| opnd1 | output | DATA_W | Operand latch 1 |
| opnd2 | output | DATA_W | Operand latch 2 |
| opnd3 | output | DATA_W | Operand latch 3 |
| opnd4 | output | DATA_W | Operand latch 4 |

## Verification
The bench goes after corner cases where the second slot could read from the wrong place. One case is a three-source one-word instruction, where a design that re-read the live middle field instead of the captured one would pick up whatever garbage sits on the decode inputs during the second slot. Another is the three-source two-word class, where a design that left port 1 enabled would write a stray value into `opnd4` instead of zero. The bench also issues back-to-back instructions, inserts idle gaps, and changes the inputs during the second slot. A design that let a first-slot read overwrite latches three and four, or that dropped or doubled the `op_valid` pulse, would show wrong operands or an extra or missing result cycle.

// File: rtl/opread_sched_pkg.sv
package opread_sched_pkg;

    typedef enum logic [2:0] {
        CLS_BASE = 3'd0,
        CLS_C21  = 3'd1,
        CLS_C22  = 3'd2,
        CLS_C31  = 3'd3,
        CLS_C32  = 3'd4,
        CLS_C41  = 3'd5,
        CLS_C42  = 3'd6,
        CLS_RSV  = 3'd7
    } op_cls_e;

    typedef enum logic [1:0] {
        LSEL_HOLD  = 2'd0,
        LSEL_PORT0 = 2'd1,
        LSEL_PORT1 = 2'd2,
        LSEL_ZERO  = 2'd3
    } lane_sel_e;

    localparam int unsigned NUM_LANES = 4;

    // class needs a second decode slot
    function automatic logic cls_two_slot(op_cls_e c);
        return (c == CLS_C31) || (c == CLS_C32) || (c == CLS_C41) || (c == CLS_C42);
    endfunction

    // middle field is a source in the first slot
    function automatic logic cls_mid_is_src(op_cls_e c);
        return (c == CLS_BASE) || (c == CLS_C21) || (c == CLS_RSV);
    endfunction

    // class has four sources
    function automatic logic cls_four_src(op_cls_e c);
        return (c == CLS_C41) || (c == CLS_C42);
    endfunction

endpackage

// File: rtl/opread_sched_port_sel.sv
module opread_sched_port_sel
    import opread_sched_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic             in_id2,
    input  logic             in_valid,
    input  op_cls_e          cls,
    input  logic [IDX_W-1:0] cur_a,
    input  logic [IDX_W-1:0] cur_b,
    input  logic [IDX_W-1:0] cur_c,
    input  logic [IDX_W-1:0] pend3,
    input  logic [IDX_W-1:0] pend4,
    input  logic             pend_four,
    output logic             en0,
    output logic [IDX_W-1:0] addr0,
    output logic             en1,
    output logic [IDX_W-1:0] addr1
);

    always_comb begin
        en0   = 1'b0;
        addr0 = '0;
        en1   = 1'b0;
        addr1 = '0;
        if (in_id2) begin
            en0   = 1'b1;
            addr0 = pend3;
            en1   = pend_four;
            addr1 = pend_four ? pend4 : '0;
        end else if (in_valid) begin
            en0   = 1'b1;
            addr0 = cur_a;
            en1   = 1'b1;
            addr1 = cls_mid_is_src(cls) ? cur_b : cur_c;
        end
    end

endmodule

// File: rtl/opread_sched_steer.sv
module opread_sched_steer
    import opread_sched_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                                in_id2,
    input  logic                                in_valid,
    input  op_cls_e                             cls,
    input  logic                                pend_four,
    input  logic [DATA_W-1:0]                   rd_data0,
    input  logic [DATA_W-1:0]                   rd_data1,
    input  logic [NUM_LANES-1:0][DATA_W-1:0]    opnd_q,
    output logic [NUM_LANES-1:0][DATA_W-1:0]    opnd_d
);

    lane_sel_e lane_sel [NUM_LANES];

    always_comb begin
        for (int i = 0; i < NUM_LANES; i++) begin
            lane_sel[i] = LSEL_HOLD;
        end
        if (in_id2) begin
            lane_sel[2] = LSEL_PORT0;
            lane_sel[3] = pend_four ? LSEL_PORT1 : LSEL_ZERO;
        end else if (in_valid) begin
            lane_sel[0] = LSEL_PORT0;
            lane_sel[1] = LSEL_PORT1;
            if (!cls_two_slot(cls)) begin
                lane_sel[2] = LSEL_ZERO;
                lane_sel[3] = LSEL_ZERO;
            end
        end
    end

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        always_comb begin
            unique case (lane_sel[g])
                LSEL_PORT0: opnd_d[g] = rd_data0;
                LSEL_PORT1: opnd_d[g] = rd_data1;
                LSEL_ZERO:  opnd_d[g] = '0;
                default:    opnd_d[g] = opnd_q[g];
            endcase
        end
    end

endmodule

// File: rtl/opread_sched.sv
module opread_sched
    import opread_sched_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        in_cls,
    input  logic [IDX_W-1:0]  cur_a,
    input  logic [IDX_W-1:0]  cur_b,
    input  logic [IDX_W-1:0]  cur_c,
    input  logic [IDX_W-1:0]  nxt_a,
    input  logic [IDX_W-1:0]  nxt_b,
    output logic              rd_en0,
    output logic [IDX_W-1:0]  rd_addr0,
    output logic              rd_en1,
    output logic [IDX_W-1:0]  rd_addr1,
    input  logic [DATA_W-1:0] rd_data0,
    input  logic [DATA_W-1:0] rd_data1,
    output logic              busy,
    output logic              op_valid,
    output logic [2:0]        op_cls,
    output logic [DATA_W-1:0] opnd1,
    output logic [DATA_W-1:0] opnd2,
    output logic [DATA_W-1:0] opnd3,
    output logic [DATA_W-1:0] opnd4
);

    typedef struct packed {
        logic                               id2;
        op_cls_e                            cls;
        logic [IDX_W-1:0]                   pend3;
        logic [IDX_W-1:0]                   pend4;
        logic                               pend_four;
        logic                               vld;
        op_cls_e                            ocls;
        logic [NUM_LANES-1:0][DATA_W-1:0]   opnd;
    } st_t;

    st_t     st_d, st_q;
    op_cls_e cls_in;
    logic [NUM_LANES-1:0][DATA_W-1:0] opnd_next;

    assign cls_in = op_cls_e'(in_cls);

    opread_sched_port_sel #(.IDX_W(IDX_W)) u_port_sel (
        .in_id2    (st_q.id2),
        .in_valid  (in_valid),
        .cls       (cls_in),
        .cur_a     (cur_a),
        .cur_b     (cur_b),
        .cur_c     (cur_c),
        .pend3     (st_q.pend3),
        .pend4     (st_q.pend4),
        .pend_four (st_q.pend_four),
        .en0       (rd_en0),
        .addr0     (rd_addr0),
        .en1       (rd_en1),
        .addr1     (rd_addr1)
    );

    opread_sched_steer #(.DATA_W(DATA_W)) u_steer (
        .in_id2    (st_q.id2),
        .in_valid  (in_valid),
        .cls       (cls_in),
        .pend_four (st_q.pend_four),
        .rd_data0  (rd_data0),
        .rd_data1  (rd_data1),
        .opnd_q    (st_q.opnd),
        .opnd_d    (opnd_next)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.opnd = opnd_next;
        if (st_q.id2) begin
            st_d.id2  = 1'b0;
            st_d.vld  = 1'b1;
            st_d.ocls = st_q.cls;
        end else if (in_valid) begin
            if (cls_two_slot(cls_in)) begin
                st_d.id2       = 1'b1;
                st_d.cls       = cls_in;
                st_d.pend_four = cls_four_src(cls_in);
                st_d.pend3     = (cls_in == CLS_C31) ? cur_b : nxt_a;
                st_d.pend4     = cls_four_src(cls_in) ? nxt_b : '0;
            end else begin
                st_d.vld  = 1'b1;
                st_d.ocls = cls_in;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.id2;
    assign op_valid = st_q.vld;
    assign op_cls   = st_q.ocls;
    assign opnd1    = st_q.opnd[0];
    assign opnd2    = st_q.opnd[1];
    assign opnd3    = st_q.opnd[2];
    assign opnd4    = st_q.opnd[3];

endmodule

// File: rtl/opread_sched_chk.sv
module opread_sched_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        in_cls,
    input logic              busy,
    input logic              op_valid,
    input logic [2:0]        op_cls,
    input logic              rd_en0,
    input logic              rd_en1,
    input logic [IDX_W-1:0]  rd_addr0,
    input logic [IDX_W-1:0]  rd_addr1,
    input logic [DATA_W-1:0] opnd1,
    input logic [DATA_W-1:0] opnd2,
    input logic [DATA_W-1:0] opnd3,
    input logic [DATA_W-1:0] opnd4
);

    logic ext_in;
    assign ext_in = (in_cls == 3'd3) || (in_cls == 3'd4) || (in_cls == 3'd5) || (in_cls == 3'd6);

    AST_EXT_ENTERS_ID2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy && ext_in) |=> busy); // R4

    AST_SHORT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !busy && !ext_in) |=> (op_valid && !busy)); // R3

    AST_SHORT_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((op_cls == 3'd0) || (op_cls == 3'd1) || (op_cls == 3'd2) || (op_cls == 3'd7)))
        |-> (opnd3 == '0 && opnd4 == '0)); // R3

    AST_THREE_SRC_NO_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && ((op_cls == 3'd3) || (op_cls == 3'd4))) |-> (opnd4 == '0)); // R5

    AST_ID2_SINGLE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && op_valid)); // R6

    AST_ID2_PORT0_ON: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rd_en0); // R5

    AST_FIRST_PAIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(opnd1) && $stable(opnd2))); // R7

    AST_DISABLED_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en0 |-> rd_addr0 == '0) and (!rd_en1 |-> rd_addr1 == '0)); // R8

    AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !busy) |=> !op_valid); // R9

endmodule

bind opread_sched opread_sched_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_cls   (in_cls),
    .busy     (busy),
    .op_valid (op_valid),
    .op_cls   (op_cls),
    .rd_en0   (rd_en0),
    .rd_en1   (rd_en1),
    .rd_addr0 (rd_addr0),
    .rd_addr1 (rd_addr1),
    .opnd1    (opnd1),
    .opnd2    (opnd2),
    .opnd3    (opnd3),
    .opnd4    (opnd4)
);

// File: tb/opread_sched_tb_top.sv
module opread_sched_tb_top;

    localparam int unsigned DW = 32;
    localparam int unsigned IW = 5;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [2:0]    in_cls;
    logic [IW-1:0] cur_a, cur_b, cur_c, nxt_a, nxt_b;
    logic          rd_en0, rd_en1;
    logic [IW-1:0] rd_addr0, rd_addr1;
    logic [DW-1:0] rd_data0, rd_data1;
    logic          busy, op_valid;
    logic [2:0]    op_cls;
    logic [DW-1:0] opnd1, opnd2, opnd3, opnd4;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] rf(logic [IW-1:0] a);
        return {a, 3'b101, a, 3'b011, a, 3'b110, a, 1'b1, 2'b10};
    endfunction

    assign rd_data0 = rf(rd_addr0);
    assign rd_data1 = rf(rd_addr1);

    opread_sched #(.DATA_W(DW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cls(in_cls),
        .cur_a(cur_a), .cur_b(cur_b), .cur_c(cur_c), .nxt_a(nxt_a), .nxt_b(nxt_b),
        .rd_en0(rd_en0), .rd_addr0(rd_addr0), .rd_en1(rd_en1), .rd_addr1(rd_addr1),
        .rd_data0(rd_data0), .rd_data1(rd_data1), .busy(busy), .op_valid(op_valid),
        .op_cls(op_cls), .opnd1(opnd1), .opnd2(opnd2), .opnd3(opnd3), .opnd4(opnd4)
    );

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(logic [2:0] cls, logic [IW-1:0] a, logic [IW-1:0] b,
                           logic [IW-1:0] c, logic [IW-1:0] na, logic [IW-1:0] nb,
                           bit gap);
        bit            ext, four, mid;
        logic [IW-1:0] p1, i3;
        logic [DW-1:0] e1, e2, e3, e4;
        ext  = (cls >= 3'd3) && (cls <= 3'd6);
        four = (cls == 3'd5) || (cls == 3'd6);
        mid  = (cls == 3'd0) || (cls == 3'd1) || (cls == 3'd7);
        p1   = mid ? b : c;
        i3   = (cls == 3'd3) ? b : na;
        e1   = rf(a);
        e2   = rf(p1);
        e3   = ext ? rf(i3) : '0;
        e4   = four ? rf(nb) : '0;

        in_valid = 1'b1; in_cls = cls;
        cur_a = a; cur_b = b; cur_c = c; nxt_a = na; nxt_b = nb;
        #1;
        chk("R2 port0 addr", DW'(rd_addr0), DW'(a));
        chk("R2 port1 addr", DW'(rd_addr1), DW'(p1));
        chk("R2 enables", DW'({rd_en0, rd_en1}), DW'(2'b11));
        @(posedge clk); @(negedge clk);
        if (ext) begin
            chk("R4 busy in second slot", DW'({busy, op_valid}), DW'(2'b10));
            chk("R5 second slot port0 addr", DW'(rd_addr0), DW'(i3));
            chk("R5 second slot port1", DW'({rd_en1, rd_addr1}), four ? DW'({1'b1, nb}) : DW'(0));
            // R6: disturb inputs during second slot
            in_valid = 1'b1; in_cls = 3'd5;
            cur_a = ~a; cur_b = ~b; cur_c = ~c; nxt_a = ~na; nxt_b = ~nb;
            #1;
            chk("R6 port0 addr unaffected", DW'(rd_addr0), DW'(i3));
            chk("R6 port1 addr unaffected", DW'(rd_addr1), four ? DW'(nb) : DW'(0));
            @(posedge clk); @(negedge clk);
        end
        chk("R9 op_valid pulse", DW'({op_valid, busy}), DW'(2'b10));
        chk("R9 op_cls", DW'(op_cls), DW'(cls));
        chk("R7 opnd1", opnd1, e1);
        chk("R7 opnd2", opnd2, e2);
        chk(ext ? "R4 R5 opnd3" : "R3 opnd3", opnd3, e3);
        chk(ext ? "R4 R5 opnd4" : "R3 opnd4", opnd4, e4);
        if (gap) begin
            in_valid = 1'b0; in_cls = 3'd6;
            cur_a = '1; cur_b = '1; cur_c = '1; nxt_a = '1; nxt_b = '1;
            #1;
            chk("R8 idle ports", DW'({rd_en0, rd_en1, rd_addr0, rd_addr1}), DW'(0));
            @(posedge clk); @(negedge clk);
            chk("R9 no result when idle", DW'(op_valid), DW'(0));
            chk("R7 hold opnd1", opnd1, e1);
            chk("R7 hold opnd3", opnd3, e3);
            chk("R7 hold opnd4", opnd4, e4);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_cls = '0;
        cur_a = '0; cur_b = '0; cur_c = '0; nxt_a = '0; nxt_b = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset operands", opnd1 | opnd2 | opnd3 | opnd4, '0);
        chk("R1 reset flags", DW'({op_valid, busy, rd_en0, rd_en1}), DW'(0));
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < 32; i++) begin
                run_one(3'(k), IW'(i), IW'(i * 7 + 3), IW'(i * 13 + 5),
                        IW'(i * 11 + 1), IW'(i * 5 + 9), (i % 4) == 3);
            end
        end
        // R6 back-to-back: extended followed at once by a short one
        run_one(3'd6, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5, 1'b0);
        run_one(3'd2, 5'd30, 5'd29, 5'd28, 5'd27, 5'd26, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule